// File: doc/BRIEF.md
# Weighted Fuzzy Rule Evaluator

This block walks a list of 16-bit words held in memory and evaluates fuzzy inference rules from it. A word that is not a marker is a pointer to an 8-bit fuzzy value, held in the low byte of the addressed memory word. While the engine is in antecedent mode, each pointed-to value pulls the running truth value (the accumulator) down by taking the minimum. The separator word 0xFFFE toggles the mode. Going from antecedents to consequents, it can scale the accumulator by a per-rule 8-bit weight. Going from consequents back to antecedents, it starts a new rule. In consequent mode, each pointed-to value is raised to the accumulator by a read-modify-write maximum. The word 0xFFFF ends the list.

All of the evaluation state is on the ports: accumulator, list pointer, weight pointer, weight-enable flag C and consequent-mode flag V. The same values are loaded at start. An interrupt request is sampled before each list word is fetched. When it is taken, the engine stops with a one-cycle pause pulse. Starting the engine again with the exposed values carries on from the word that was not yet fetched. A fresh evaluation is started with accumulator 0xFF and V = 0.

Top module: `fuzzy_rule_eval`

## Requirements
- R1: After reset, busy, done and paused are 0, the accumulator, both pointers and the C and V flags are 0, and no memory access is made.
- R2: In antecedent mode (V = 0), each pointer word sets the accumulator to the minimum of itself and the low byte of the addressed memory word.
- R3: In consequent mode (V = 1), each pointer word rewrites the addressed memory word to {8'h00, max(low byte, accumulator)}. This is the only case in which memory is written.
- R4: A 0xFFFE word read with V = 0 sets V to 1. If C = 0, the accumulator is left unchanged.
- R5: A 0xFFFE word read with V = 0 and C = 1 replaces the accumulator with bits [15:8] of accumulator × (low byte of the memory word at the weight pointer), then adds one to the weight pointer. The weight pointer changes in no other way while busy.
- R6: A 0xFFFE word read with V = 1 clears V and sets the accumulator to 0xFF, which starts a new rule.
- R7: A 0xFFFF word ends the evaluation with a one-cycle done pulse. At that point the accumulator holds the last rule's (weighted) truth value, the list pointer is one past the end word, and V is 1 for a well-formed list or 0 if the list ended in antecedents.
- R8: With start sampled at clock edge 0, done rises at edge 1 + 3·N + 2·W. Here N is the number of list words including the end word, and W is the number of weighted separators.
- R9: An interrupt request seen before a list-word fetch stops the engine with a one-cycle paused pulse and busy low. No memory access is made, and the accumulator holds its value while the engine is idle and start is low.
- R10: Restarting with the accumulator, pointers and flags exposed at a pause gives the same final accumulator, pointers, flags and memory contents as an uninterrupted run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load the state below and begin evaluation (sampled while idle) |
| irq | input | 1 | Pending interrupt request |
| ld_acc | input | 8 | Accumulator value to load |
| ld_ptr | input | 16 | List pointer to load |
| ld_wptr | input | 16 | Weight pointer to load |
| ld_c | input | 1 | Weight-enable flag to load |
| ld_v | input | 1 | Consequent-mode flag to load |
| mem_addr | output | 16 | Memory word address |
| mem_rd | output | 1 | Read strobe; data is on mem_rdata in the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data from the previous cycle's read |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle end-of-list pulse |
| paused | output | 1 | One-cycle interrupt-stop pulse |
| acc | output | 8 | Accumulator |
| ptr | output | 16 | List pointer |
| wptr | output | 16 | Weight pointer |
| flag_c | output | 1 | Weight-enable flag |
| flag_v | output | 1 | Consequent-mode flag |

## Verification
The assertions rely on start being raised only while busy is low. They also rely on the memory returning the read data exactly one cycle after mem_rd. The bench's memory model has that one-cycle latency, and its driver raises start only after the previous run has ended in done or paused. Interrupts are raised at fixed cycle offsets inside a weighted run and held until the pause pulse appears. This places the pauses at word fetches in the middle of a rule, and the resumed runs are then compared against an uninterrupted reference.

// File: rtl/fuzzy_rule_eval.sv
module fuzzy_rule_eval #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          irq,
  input  logic [VW-1:0] ld_acc,
  input  logic [AW-1:0] ld_ptr,
  input  logic [AW-1:0] ld_wptr,
  input  logic          ld_c,
  input  logic          ld_v,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          paused,
  output logic [VW-1:0] acc,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] wptr,
  output logic          flag_c,
  output logic          flag_v
);
  localparam logic [DW-1:0] END_W = '1;
  localparam logic [DW-1:0] SEP_W = END_W - 1'b1;
  localparam logic [VW-1:0] TOP_V = '1;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_FETCH, S_DEC, S_OPER, S_SKIP, S_WT1, S_WT2, S_WT3, S_FIN
  } st_t;

  st_t           st;
  logic [AW-1:0] opaddr;
  logic [VW-1:0] wgt;

  wire            is_end = (mem_rdata == END_W);
  wire            is_sep = (mem_rdata == SEP_W);
  wire            do_wt  = is_sep && !flag_v && flag_c;
  wire [VW-1:0]   op     = mem_rdata[VW-1:0];
  wire [VW-1:0]   mx     = (op > acc) ? op : acc;
  wire [2*VW-1:0] prod   = acc * wgt;

  assign busy      = (st != S_IDLE);
  assign mem_rd    = (st == S_FETCH && !irq) ||
                     (st == S_DEC && !is_end && (!is_sep || do_wt));
  assign mem_addr  = (st == S_FETCH) ? ptr :
                     (st == S_DEC)   ? (is_sep ? wptr : AW'(mem_rdata)) : opaddr;
  assign mem_we    = (st == S_OPER) && flag_v;
  assign mem_wdata = DW'(mx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      acc    <= '0;
      ptr    <= '0;
      wptr   <= '0;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
      opaddr <= '0;
      wgt    <= '0;
      done   <= 1'b0;
      paused <= 1'b0;
    end else begin
      done   <= 1'b0;
      paused <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          acc    <= ld_acc;
          ptr    <= ld_ptr;
          wptr   <= ld_wptr;
          flag_c <= ld_c;
          flag_v <= ld_v;
          st     <= S_SETUP;
        end
        S_SETUP: st <= S_FETCH;
        S_FETCH: if (irq) begin
          paused <= 1'b1;
          st     <= S_IDLE;
        end else begin
          st <= S_DEC;
        end
        S_DEC: begin
          ptr <= ptr + 1'b1;
          if (is_end) begin
            st <= S_FIN;
          end else if (is_sep) begin
            flag_v <= !flag_v;
            if (flag_v) acc <= TOP_V;
            st <= do_wt ? S_WT1 : S_SKIP;
          end else begin
            opaddr <= AW'(mem_rdata);
            st     <= S_OPER;
          end
        end
        S_OPER: begin
          if (!flag_v && op < acc) acc <= op;
          st <= S_FETCH;
        end
        S_SKIP: st <= S_FETCH;
        S_WT1: begin
          wgt <= op;
          st  <= S_WT2;
        end
        S_WT2: begin
          acc  <= prod[2*VW-1:VW];
          wptr <= wptr + 1'b1;
          st   <= S_WT3;
        end
        S_WT3: st <= S_FETCH;
        S_FIN: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fuzzy_rule_eval_chk.sv
module fuzzy_rule_eval_chk #(
  parameter int AW = 16,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          paused,
  input logic          mem_rd,
  input logic          mem_we,
  input logic          flag_v,
  input logic [VW-1:0] acc,
  input logic [AW-1:0] wptr
);
  p_we_conseq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (flag_v && busy));

  p_no_rdwr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));

  p_wptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && wptr != $past(wptr)) |-> (wptr == $past(wptr) + 1'b1));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!paused && !busy));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_we));

  p_acc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(acc));

  p_pause_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    paused |=> !paused);
endmodule

bind fuzzy_rule_eval fuzzy_rule_eval_chk #(.AW(AW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .paused(paused), .mem_rd(mem_rd), .mem_we(mem_we), .flag_v(flag_v),
  .acc(acc), .wptr(wptr)
);

// File: tb/fuzzy_rule_eval_bench.sv
module fuzzy_rule_eval_bench;
  localparam int CLK_P = 10;
  localparam int WBASE = 'h60;

  logic        clk = 0, rst_n = 0, start = 0, irq = 0;
  logic [7:0]  ld_acc = 0;
  logic [15:0] ld_ptr = 0, ld_wptr = 0;
  logic        ld_c = 0, ld_v = 0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_we, busy, done, paused, flag_c, flag_v;
  logic [7:0]  acc;
  logic [15:0] ptr, wptr;

  always #(CLK_P/2) clk = ~clk;

  fuzzy_rule_eval u_fuzzy_rule_eval (
    .clk(clk), .rst_n(rst_n), .start(start), .irq(irq), .ld_acc(ld_acc),
    .ld_ptr(ld_ptr), .ld_wptr(ld_wptr), .ld_c(ld_c), .ld_v(ld_v),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .paused(paused), .acc(acc),
    .ptr(ptr), .wptr(wptr), .flag_c(flag_c), .flag_v(flag_v)
  );

  logic [15:0] mem [256];
  logic [15:0] gm  [256];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= start ? 0 : cyc + 1;

  typedef struct { logic [7:0] a; logic v; int p; int w; int cy; } exp_t;
  exp_t q[$];

  task automatic chk(input string rq, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  task automatic init_mem();
    int l1[11] = '{'h40, 'h41, 'hFFFE, 'h50, 'h51, 'hFFFE, 'h42, 'h43, 'hFFFE, 'h50, 'hFFFF};
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    for (int i = 0; i < 11; i++) mem[i] = l1[i][15:0];
    mem['h20] = 'h44; mem['h21] = 'h45; mem['h22] = 'hFFFF;
    mem['h40] = 'h90; mem['h41] = 'h60; mem['h42] = 'hC0; mem['h43] = 'hB0;
    mem['h44] = 'h70; mem['h45] = 'h35;
    mem['h50] = 'h20; mem['h51] = 'h80;
    mem[WBASE] = 'h80; mem[WBASE+1] = 'hFF;
    for (int i = 0; i < 256; i++) gm[i] = mem[i];
  endtask

  task automatic model(input int base, input bit c, output exp_t e);
    logic [7:0] a = 8'hFF;
    logic v = 0;
    int p = base, w = WBASE, n = 0, ws = 0;
    logic [15:0] wd;
    forever begin
      wd = gm[p[7:0]]; p++; n++;
      if (wd == 16'hFFFF) break;
      if (wd == 16'hFFFE) begin
        if (v) begin v = 0; a = 8'hFF; end
        else begin
          v = 1;
          if (c) begin a = 8'((16'(a) * 16'(gm[w][7:0])) >> 8); w++; ws++; end
        end
      end else if (!v) begin
        if (gm[wd[7:0]][7:0] < a) a = gm[wd[7:0]][7:0];
      end else if (a > gm[wd[7:0]][7:0]) gm[wd[7:0]] = {8'h00, a};
    end
    e.a = a; e.v = v; e.p = p; e.w = w; e.cy = 1 + 3*n + 2*ws;
  endtask

  task automatic kick(input logic [7:0] a, input int p, input int w, input bit c, input bit v);
    ld_acc = a; ld_ptr = p[15:0]; ld_wptr = w[15:0]; ld_c = c; ld_v = v;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic check_mem(input string rq);
    for (int i = 'h50; i < 'h52; i++) chk(rq, mem[i], gm[i]);
  endtask

  task automatic run(input int base, input bit c, input string rq);
    exp_t e;
    init_mem();
    model(base, c, e);
    q.push_back(e);
    kick(8'hFF, base, WBASE, c, 1'b0);
    while (!done) @(negedge clk);
    @(negedge clk);
    check_mem(rq);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      if (q.size() == 0) chk("R7 unexpected done", 1, 0);
      else begin
        e = q.pop_front();
        chk("R2/R5 final acc", acc, e.a);
        chk("R7 final V", flag_v, e.v);
        chk("R7 list pointer", ptr, e.p);
        chk("R5 weight pointer", wptr, e.w);
        if (e.cy != 0) chk("R8 cycle count", cyc, e.cy);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    exp_t e;
    logic [7:0] sa; logic [15:0] sp, sw; logic sc, sv;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 paused", paused, 0);
    chk("R1 acc", acc, 0);
    chk("R1 ptr", ptr, 0);
    chk("R1 flags", {flag_c, flag_v}, 0);
    chk("R1 mem idle", {mem_rd, mem_we}, 0);
    rst_n = 1;
    @(negedge clk);

    run(0, 1'b0, "R3 R4 R6 unweighted memory");
    run(0, 1'b1, "R3 R5 weighted memory");
    run('h20, 1'b0, "R2 R7 malformed");

    init_mem();
    model(0, 1'b1, e);
    e.cy = 0;
    q.push_back(e);
    kick(8'hFF, 0, WBASE, 1'b1, 1'b0);
    for (int k = 0; k < 2; k++) begin
      repeat (k == 0 ? 12 : 8) @(negedge clk);
      irq = 1;
      while (!paused) @(negedge clk);
      chk("R9 busy low at pause", busy, 0);
      chk("R9 no access at pause", {mem_rd, mem_we}, 0);
      sa = acc; sp = ptr; sw = wptr; sc = flag_c; sv = flag_v;
      irq = 0;
      repeat (3) @(negedge clk);
      chk("R9 paused pulse", paused, 0);
      chk("R9 acc held while idle", acc, sa);
      chk("R9 still idle", busy, 0);
      kick(sa, sp, sw, sc, sv);
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check_mem("R10 resumed memory");

    repeat (3) @(negedge clk);
    chk("R7 queue drained", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule